// File: doc/BRIEF.md
# Hierarchical Scan-Line Winding Buffer

This block holds the edge crossings of one raster line and turns them into filled pixel runs. An edge-table pass upstream reports each place where a path edge crosses the current line. It gives a pixel position and says whether the edge was heading up or down. The buffer keeps a 2-bit code for every pixel of the line. It also keeps a one-bit occupancy flag for each 16-pixel section, so the sweep can pass over an untouched section without reading its pixel entries.

Use follows a fixed cycle. A `line_start` pulse opens a new line. It clears every section flag and the rescan indication in a single cycle. Crossings are written while the line is recording. A `resolve_start` pulse then starts a sweep from left to right. The sweep keeps a 6-bit signed winding count and applies either the non-zero or the even-odd fill rule. It emits each maximal filled run as a start position and a length.

Pixel entries are never cleared in bulk. The sweep zeroes each entry as it reads it. An entry in an unflagged section is therefore already zero when its section is next used. When two crossings land on the same pixel, that pixel is marked as overflowed and `rescan` is raised. The upstream pass then replays the edges of that line, so the entry width never has to grow.

The controller has four states:
- ST_IDLE moves to ST_RECORD on `line_start`.
- ST_RECORD moves to ST_SWEEP on `resolve_start`.
- ST_SWEEP moves to ST_FLUSH once the sweep position reaches the line width.
- ST_FLUSH always returns to ST_IDLE.

Top module: `scanline_winding_buf`

## Requirements
- R1: After reset, `busy`, `done`, `span_valid` and `rescan` are all low, and the controller is waiting for a new line.
- R2: `line_start` in the idle state clears all section flags and `rescan`, and opens recording. While the line is recording or being swept, `line_start` has no effect.
- R3: A crossing with `cross_up`=1 stores code 01, which adds +1 to the winding count. A crossing with `cross_up`=0 stores code 10, which adds -1. Code 00 means no crossing. A crossing sets the flag of section `cross_x`/16. A crossing with `cross_x` >= 240 is discarded and sets no flag.
- R4: A second crossing on a pixel that already holds a code stores code 11. Code 11 adds 0 to the winding count. It also raises `rescan`, which stays high until the next accepted `line_start`.
- R5: With `fill_evenodd`=0 captured at `resolve_start`, pixel x is filled when the winding count is non-zero. The winding count of pixel x is the 6-bit two's-complement sum of the contributions of pixels 0 to x.
- R6: With `fill_evenodd`=1 captured at `resolve_start`, pixel x is filled when that winding count is odd.
- R7: Every maximal run of filled pixels is reported exactly once, on a `span_valid` cycle, as (`span_x`, `span_len`) with `span_len` >= 1. Runs are reported in ascending order. A run that reaches pixel 239 is reported when the sweep finishes.
- R8: A sweep keeps `busy` high for 16 cycles per flagged section, plus 1 cycle per unflagged section, plus 1 final cycle. `done` pulses for one cycle right after `busy` falls. No span is reported after that pulse.
- R9: Every entry the sweep reads is cleared. A later line that flags the same section sees only its own crossings.
- R10: Crossings presented outside the recording state are ignored.
- R11: `resolve_start` has an effect only in the recording state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Open a new line (idle state only) |
| cross_valid | input | 1 | Crossing event strobe |
| cross_x | input | 8 | Pixel position of the crossing |
| cross_up | input | 1 | 1 = upward edge (+1), 0 = downward edge (-1) |
| resolve_start | input | 1 | Start the sweep (recording state only) |
| fill_evenodd | input | 1 | Fill rule captured at sweep start: 0 non-zero, 1 even-odd |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse after the sweep ends |
| rescan | output | 1 | Overflowed pixel seen on this line |
| span_valid | output | 1 | Span report strobe |
| span_x | output | 8 | First pixel of the span |
| span_len | output | 8 | Number of pixels in the span |

## Verification
The final sweep cycle can both close or extend a run and finish the line. A crossing on pixel 239 creates this case, and so does a lone upward crossing at pixel 0, which fills the whole line. Each run of the bench builds its expected span list and its expected busy-cycle count from the recorded crossings. The run is judged against both. The span list must end with the flushed run, and the cycle count must match exactly, which also shows that an empty section costs a single cycle.

// File: rtl/swb_pkg.sv
package swb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECORD = 2'd1,
        ST_SWEEP  = 2'd2,
        ST_FLUSH  = 2'd3
    } swb_state_e;

    localparam logic [1:0] CODE_NONE = 2'b00;
    localparam logic [1:0] CODE_UP   = 2'b01;
    localparam logic [1:0] CODE_DOWN = 2'b10;
    localparam logic [1:0] CODE_OVF  = 2'b11;

    // Combine a new crossing with whatever the pixel already holds.
    function automatic logic [1:0] code_merge(input logic [1:0] prev, input logic up);
        if (prev == CODE_NONE) begin
            return up ? CODE_UP : CODE_DOWN;
        end
        return CODE_OVF;
    endfunction

endpackage

// File: rtl/swb_entry_store.sv
module swb_entry_store
    import swb_pkg::*;
#(
    parameter int WIDTH = 240,
    parameter int XW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [XW-1:0] wr_x,
    input  logic          wr_up,
    output logic          wr_hit,
    input  logic          clr_en,
    input  logic [XW-1:0] clr_x,
    input  logic [XW-1:0] rd_x,
    output logic [1:0]    rd_code
);

    logic [2*WIDTH-1:0] ent_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            for (int i = 0; i < WIDTH; i++) begin
                if (wr_en && wr_x == XW'(i)) begin
                    ent_q[2*i +: 2] <= code_merge(ent_q[2*i +: 2], wr_up);
                end else if (clr_en && clr_x == XW'(i)) begin
                    ent_q[2*i +: 2] <= CODE_NONE;
                end
            end
        end
    end

    always_comb begin
        rd_code = CODE_NONE;
        wr_hit  = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (rd_x == XW'(i)) begin
                rd_code = ent_q[2*i +: 2];
            end
            if (wr_x == XW'(i) && ent_q[2*i +: 2] != CODE_NONE) begin
                wr_hit = 1'b1;
            end
        end
    end

    // R4: a repeated write to a pixel leaves the overflow code behind
    p_repeat_marks_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && rd_x == wr_x) |=> (rd_x != $past(wr_x)) || (rd_code == CODE_OVF) || $past(clr_en))
        else $error("repeated crossing did not mark overflow");

endmodule

// File: rtl/swb_section_map.sv
module swb_section_map #(
    parameter int NSEC = 15,
    parameter int SW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          set_en,
    input  logic [SW-1:0] set_idx,
    input  logic [SW-1:0] rd_idx,
    output logic          rd_occ
);

    logic [NSEC-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (clr_all) begin
            occ_q <= '0;
        end else if (set_en) begin
            occ_q[set_idx] <= 1'b1;
        end
    end

    assign rd_occ = occ_q[rd_idx];

    // R3: a recorded crossing flags its section on the next cycle
    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_all) |=> occ_q[$past(set_idx)])
        else $error("section flag not set after crossing");

    // R2: a new line leaves no section flagged
    p_flags_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (occ_q == '0))
        else $error("section flags survive line start");

endmodule

// File: rtl/swb_span_gen.sv
module swb_span_gen #(
    parameter int WIDTH = 240,
    parameter int XW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic [XW-1:0] step_x,
    input  logic [XW-1:0] step_len,
    input  logic          step_fill,
    input  logic          flush,
    output logic          span_valid,
    output logic [XW-1:0] span_x,
    output logic [XW-1:0] span_len
);

    logic          in_run_q;
    logic [XW-1:0] run_x_q;
    logic [XW-1:0] run_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_run_q   <= 1'b0;
            run_x_q    <= '0;
            run_len_q  <= '0;
            span_valid <= 1'b0;
            span_x     <= '0;
            span_len   <= '0;
        end else begin
            span_valid <= 1'b0;
            if (flush) begin
                if (in_run_q) begin
                    span_valid <= 1'b1;
                    span_x     <= run_x_q;
                    span_len   <= run_len_q;
                    in_run_q   <= 1'b0;
                end
            end else if (step_en) begin
                if (step_fill) begin
                    if (in_run_q) begin
                        run_len_q <= run_len_q + step_len;
                    end else begin
                        run_x_q   <= step_x;
                        run_len_q <= step_len;
                        in_run_q  <= 1'b1;
                    end
                end else if (in_run_q) begin
                    span_valid <= 1'b1;
                    span_x     <= run_x_q;
                    span_len   <= run_len_q;
                    in_run_q   <= 1'b0;
                end
            end
        end
    end

    // R7: every reported run is non-empty and stays on the line
    p_span_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        span_valid |-> (span_len != '0) && (int'(span_x) + int'(span_len) <= WIDTH))
        else $error("span out of bounds");

    // R7: a report always closes the open run
    p_span_closes_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        span_valid |-> !in_run_q || $past(step_en && step_fill && !flush))
        else $error("run left open after report");

endmodule

// File: rtl/scanline_winding_buf.sv
module scanline_winding_buf
    import swb_pkg::*;
#(
    parameter int WIDTH = 240,
    parameter int SEC   = 16,
    parameter int WW    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic       cross_valid,
    input  logic [7:0] cross_x,
    input  logic       cross_up,
    input  logic       resolve_start,
    input  logic       fill_evenodd,
    output logic       busy,
    output logic       done,
    output logic       rescan,
    output logic       span_valid,
    output logic [7:0] span_x,
    output logic [7:0] span_len
);

    localparam int            NSEC    = WIDTH / SEC;
    localparam int            XW      = 8;
    localparam int            SW      = (NSEC > 1) ? $clog2(NSEC) : 1;
    localparam logic [XW-1:0] WIDTH_X = XW'(WIDTH);
    localparam logic [XW-1:0] SEC_X   = XW'(SEC);

    initial begin
        if (WIDTH % SEC != 0) $error("line width must be a whole number of sections");
        if (WIDTH >= (1 << XW)) $error("line width exceeds position range");
    end

    swb_state_e           state_q, state_d;
    logic [XW-1:0]        pos_q;
    logic signed [WW-1:0] wind_q;
    logic                 rule_q;
    logic                 rescan_q;
    logic                 done_q;

    logic                 rec_wr;
    logic                 wr_hit;
    logic [1:0]           rd_code;
    logic                 rd_occ;
    logic [SW-1:0]        rd_sec;
    logic [SW-1:0]        wr_sec;
    logic                 sweeping;
    logic                 skip;
    logic [XW-1:0]        step_len;
    logic [XW-1:0]        pos_next;
    logic signed [WW-1:0] step_val;
    logic signed [WW-1:0] wind_next;
    logic signed [WW-1:0] wind_eval;
    logic                 fill_now;

    // ---------------- datapath decode ----------------
    assign sweeping = (state_q == ST_SWEEP);
    assign rec_wr   = (state_q == ST_RECORD) && cross_valid && (cross_x < WIDTH_X);
    assign wr_sec   = SW'(cross_x / SEC_X);
    assign rd_sec   = SW'(pos_q / SEC_X);
    assign skip     = sweeping && ((pos_q % SEC_X) == '0) && !rd_occ;
    assign step_len = skip ? SEC_X : XW'(1);
    assign pos_next = pos_q + step_len;

    always_comb begin
        unique case (rd_code)
            CODE_UP:   step_val = WW'(1);
            CODE_DOWN: step_val = '1;
            default:   step_val = '0;
        endcase
    end

    assign wind_next = wind_q + step_val;
    assign wind_eval = skip ? wind_q : wind_next;
    assign fill_now  = rule_q ? wind_eval[0] : (wind_eval != '0);

    // ---------------- submodules ----------------
    swb_entry_store #(
        .WIDTH (WIDTH),
        .XW    (XW)
    ) u_entries (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rec_wr),
        .wr_x    (cross_x),
        .wr_up   (cross_up),
        .wr_hit  (wr_hit),
        .clr_en  (sweeping && !skip),
        .clr_x   (pos_q),
        .rd_x    (pos_q),
        .rd_code (rd_code)
    );

    swb_section_map #(
        .NSEC (NSEC),
        .SW   (SW)
    ) u_sections (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all ((state_q == ST_IDLE) && line_start),
        .set_en  (rec_wr),
        .set_idx (wr_sec),
        .rd_idx  (rd_sec),
        .rd_occ  (rd_occ)
    );

    swb_span_gen #(
        .WIDTH (WIDTH),
        .XW    (XW)
    ) u_spans (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (sweeping),
        .step_x     (pos_q),
        .step_len   (step_len),
        .step_fill  (fill_now),
        .flush      (state_q == ST_FLUSH),
        .span_valid (span_valid),
        .span_x     (span_x),
        .span_len   (span_len)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (line_start)       state_d = ST_RECORD;
            ST_RECORD: if (resolve_start)    state_d = ST_SWEEP;
            ST_SWEEP:  if (pos_next >= WIDTH_X) state_d = ST_FLUSH;
            ST_FLUSH:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- outputs and sweep registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            wind_q   <= '0;
            rule_q   <= 1'b0;
            rescan_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FLUSH);
            unique case (state_q)
                ST_IDLE: begin
                    if (line_start) rescan_q <= 1'b0;
                end
                ST_RECORD: begin
                    if (rec_wr && wr_hit) rescan_q <= 1'b1;
                    if (resolve_start) begin
                        pos_q  <= '0;
                        wind_q <= '0;
                        rule_q <= fill_evenodd;
                    end
                end
                ST_SWEEP: begin
                    pos_q <= pos_next;
                    if (!skip) wind_q <= wind_next;
                end
                default: ;
            endcase
        end
    end

    assign busy   = (state_q == ST_SWEEP) || (state_q == ST_FLUSH);
    assign done   = done_q;
    assign rescan = rescan_q;

    // R4: rescan only rises after a crossing accepted while recording
    p_rescan_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rescan_q) |-> $past((state_q == ST_RECORD) && cross_valid))
        else $error("rescan raised without a crossing");

    // R9: entries of an unflagged section are already clear when the sweep passes
    p_lazy_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sweeping && !rd_occ) |-> (rd_code == CODE_NONE))
        else $error("stale entry in unflagged section");

    // R8: the flush cycle ends the sweep and produces the done pulse
    p_flush_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (state_q == ST_IDLE) && done)
        else $error("flush did not end sweep");

    // R8: the sweep position only moves forward
    p_sweep_advances_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sweeping |=> (pos_q > $past(pos_q)))
        else $error("sweep position stalled");

endmodule

// File: tb/sim_scanline_winding_buf.sv
module sim_scanline_winding_buf;

    localparam int W  = 240;
    localparam int S  = 16;
    localparam int NS = W / S;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic       cross_valid = 1'b0;
    logic [7:0] cross_x = '0;
    logic       cross_up = 1'b0;
    logic       resolve_start = 1'b0;
    logic       fill_evenodd = 1'b0;
    logic       busy, done, rescan, span_valid;
    logic [7:0] span_x, span_len;

    int checks = 0;
    int fails  = 0;
    int mcode [W];
    bit mflag [NS];
    int got_x [256];
    int got_len [256];
    int got_n = 0;
    int busy_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    scanline_winding_buf u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_start    (line_start),
        .cross_valid   (cross_valid),
        .cross_x       (cross_x),
        .cross_up      (cross_up),
        .resolve_start (resolve_start),
        .fill_evenodd  (fill_evenodd),
        .busy          (busy),
        .done          (done),
        .rescan        (rescan),
        .span_valid    (span_valid),
        .span_x        (span_x),
        .span_len      (span_len)
    );

    always @(negedge clk) begin
        if (span_valid && got_n < 256) begin
            got_x[got_n]   = int'(span_x);
            got_len[got_n] = int'(span_len);
            got_n++;
        end
        if (busy) busy_cnt++;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic begin_line();
        @(negedge clk) line_start = 1'b1;
        @(negedge clk) line_start = 1'b0;
        for (int i = 0; i < W; i++) mcode[i] = 0;
        for (int s = 0; s < NS; s++) mflag[s] = 1'b0;
    endtask

    task automatic drive_cross(input int x, input bit up);
        @(negedge clk);
        cross_valid = 1'b1;
        cross_x     = 8'(x);
        cross_up    = up;
        @(negedge clk);
        cross_valid = 1'b0;
    endtask

    task automatic put(input int x, input bit up);
        drive_cross(x, up);
        if (x < W) begin
            mcode[x] = (mcode[x] == 0) ? (up ? 1 : 2) : 3;
            mflag[x / S] = 1'b1;
        end
    endtask

    task automatic resolve(input bit eo, input bit mid_ls, input string req);
        int ex [256];
        int el [256];
        int en = 0;
        int w = 0;
        bit inrun = 1'b0;
        bit f;
        int cyc = 1;
        int t = 0;
        for (int x = 0; x < W; x++) begin
            w += (mcode[x] == 1) ? 1 : ((mcode[x] == 2) ? -1 : 0);
            f = eo ? ((w % 2) != 0) : (w != 0);
            if (f) begin
                if (!inrun) begin
                    ex[en] = x;
                    el[en] = 1;
                    inrun  = 1'b1;
                end else begin
                    el[en]++;
                end
            end else if (inrun) begin
                en++;
                inrun = 1'b0;
            end
        end
        if (inrun) en++;
        for (int s = 0; s < NS; s++) cyc += mflag[s] ? S : 1;

        @(negedge clk);
        fill_evenodd = eo;
        got_n = 0;
        busy_cnt = 0;
        resolve_start = 1'b1;
        @(negedge clk) resolve_start = 1'b0;
        if (mid_ls) begin
            line_start = 1'b1;
            repeat (3) @(negedge clk);
            line_start = 1'b0;
        end
        do begin
            @(negedge clk);
            t++;
        end while (!done && t < 400);
        @(negedge clk);
        check(t < 400, "R8", "done pulse seen", t, 0);
        check(got_n == en, req, "span count", got_n, en);
        for (int i = 0; i < en && i < got_n; i++) begin
            check(got_x[i] == ex[i], req, "span start", got_x[i], ex[i]);
            check(got_len[i] == el[i], req, "span length", got_len[i], el[i]);
        end
        check(busy_cnt == cyc, "R8", "busy cycles", busy_cnt, cyc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy, "R1", "busy after reset", int'(busy), 0);
        check(!done, "R1", "done after reset", int'(done), 0);
        check(!span_valid, "R1", "span_valid after reset", int'(span_valid), 0);
        check(!rescan, "R1", "rescan after reset", int'(rescan), 0);

        // R11: resolve_start in idle is ignored
        @(negedge clk) resolve_start = 1'b1;
        @(negedge clk) resolve_start = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy, "R11", "busy after idle resolve", int'(busy), 0);

        // R8: empty line costs one cycle per section plus flush
        begin_line();
        resolve(1'b0, 1'b0, "R8");

        // R5 / R6 / R7: sweep of up/down pairs under both rules
        for (int k = 0; k < 19; k++) begin
            int a = k * 13;
            int b = a + 1 + ((k * 11) % 60);
            if (b > W - 1) b = W - 1;
            begin_line();
            if (k % 3 == 2) begin
                put(b, 1'b0);
                put(a, 1'b0);
            end else begin
                put(a, 1'b1);
                put(b, 1'b0);
            end
            resolve(k[0], 1'b0, k[0] ? "R6" : "R5");
        end

        // R6: nested windings differ between rules
        begin_line();
        put(10, 1'b1); put(50, 1'b1); put(100, 1'b0); put(200, 1'b0);
        resolve(1'b0, 1'b0, "R5");
        begin_line();
        put(10, 1'b1); put(50, 1'b1); put(100, 1'b0); put(200, 1'b0);
        resolve(1'b1, 1'b0, "R6");

        // R4: overflow pixel, rescan, zero contribution
        begin_line();
        put(30, 1'b1);
        put(30, 1'b0);
        check(rescan, "R4", "rescan after double crossing", int'(rescan), 1);
        put(60, 1'b1); put(90, 1'b0);
        resolve(1'b0, 1'b0, "R4");
        check(rescan, "R4", "rescan held after sweep", int'(rescan), 1);
        begin_line();
        check(!rescan, "R4", "rescan cleared by line start", int'(rescan), 0);

        // R7: runs touching the last pixel are flushed
        put(239, 1'b1);
        resolve(1'b0, 1'b0, "R7");
        begin_line();
        put(0, 1'b1);
        resolve(1'b1, 1'b0, "R7");

        // R3: out-of-range crossings discarded, no flag
        begin_line();
        put(240, 1'b1);
        put(255, 1'b0);
        resolve(1'b0, 1'b0, "R3");

        // R9: previously swept entries do not leak into a later line
        begin_line();
        put(5, 1'b1); put(8, 1'b0);
        resolve(1'b0, 1'b0, "R9");
        begin_line();
        put(12, 1'b1);
        resolve(1'b0, 1'b0, "R9");

        // R10: crossing in idle is ignored
        drive_cross(40, 1'b1);
        begin_line();
        put(45, 1'b0);
        resolve(1'b0, 1'b0, "R10");

        // R2: line_start during the sweep is ignored
        begin_line();
        put(20, 1'b1); put(220, 1'b0);
        resolve(1'b0, 1'b1, "R2");
        check(!busy, "R2", "busy after sweep", int'(busy), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule